// File: doc/BRIEF.md
# I2C SCL Tap-Based Clock Divider

This block turns the bus clock into the timing of one I2C bit for a master. The byte controller requests a bit through a valid/ready handshake. The block then drives SCL low for one half period and releases it for the other half. It marks the SCL edges with single-cycle ticks and gives one strobe at the point where SDA is to be sampled. When the bit period is over it reports completion.

The period is not a binary count. A 6-bit divider code holds two 3-bit indices. The scaling index sits in code bits 4:2. The tap index is split: bits 1:0 of the code are its low bits and bit 5 is its top bit. The tap index picks a tap count, and the scaling index picks a lead length and a tap spacing. Half of the SCL period is lead + (taps − 1) × spacing + 2 bus clocks. While the block releases SCL and still senses it low, a slave is stretching the clock, and the high phase waits.

Back-pressure rules: `bit_req_ready` is high only while no bit is in progress. A request is taken on a clock edge where `bit_req_valid` and `bit_req_ready` are both high. `bit_req_valid` may stay high through a bit. The block takes no notice of it until ready returns. The divider code is captured only when a request is taken.

Top module: `scl_tap_clkgen`

## Requirements
- R1: After reset the block is idle: `bit_req_ready`=1, and `scl_drive_low`, `scl_fall_tick`, `scl_rise_tick`, `sda_sample` and `bit_done` are all 0.
- R2: The code is decoded as tap index t = {code[5], code[1], code[0]} and scale index s = code[4:2].
- R3: Tap index t = 0..7 gives tap counts 9, 10, 12, 15, 5, 6, 7, 8. Scale index s = 0..7 gives lead lengths 4, 4, 6, 6, 14, 30, 62, 126 and tap spacings 2^s. The half period is H = lead + (taps − 1) × spacing + 2.
- R4: Counting from the accepting edge (cycle 0), `scl_drive_low` is high for exactly H cycles (cycles 0..H−1). With no stretching, the whole bit lasts 2H cycles.
- R5: `bit_req_ready` is low from the cycle after acceptance until the bit completes. A valid that is held during a bit is not taken early. If valid is still high when ready returns, the next bit starts on the following edge.
- R6: `scl_fall_tick` pulses for one cycle in cycle 0. `scl_rise_tick` pulses for one cycle in cycle H.
- R7: `sda_sample` pulses once per bit, lead cycles after the rise tick, counted in cycles where SCL is sensed high.
- R8: If `scl_in` is low during the high phase, the high-phase count holds. The sample strobe and completion both move later by the number of stretched cycles.
- R9: A change of `div_code` while a bit is in progress does not change the timing of that bit.
- R10: `bit_done` pulses for one cycle in the cycle in which ready returns high. Without stretching that is cycle 2H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | active-low asynchronous reset |
| div_code | input | 6 | divider code, captured when a bit is accepted |
| bit_req_valid | input | 1 | byte controller requests one bit period |
| bit_req_ready | output | 1 | block is idle and can take a request |
| scl_in | input | 1 | sensed level of the SCL line |
| scl_drive_low | output | 1 | pull SCL low (low phase) |
| scl_fall_tick | output | 1 | one-cycle pulse at the start of the low phase |
| scl_rise_tick | output | 1 | one-cycle pulse at the start of the high phase |
| sda_sample | output | 1 | one-cycle strobe to sample SDA |
| bit_done | output | 1 | one-cycle pulse when the bit period ends |

## Verification
Every output is registered, so each result is due at a fixed cycle counted from the accepting edge. The fall tick comes in cycle 0, the rise tick in cycle H, the sample strobe in cycle H + lead + stretch, and completion in cycle 2H + stretch. The bench counts clock edges from acceptance and samples every output on the falling edge in between. It records the cycle index of each pulse and the number of low cycles, and compares them with H and lead values computed from the tables. This is done for all 64 codes, and for selected codes with stretching and with a held request.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int CODE_W = 6;
  localparam int IDX_W  = 3;
  localparam int CNT_W  = 11;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

  // tap count per tap index
  function automatic logic [3:0] tap_count(input logic [IDX_W-1:0] t);
    case (t)
      3'd0: tap_count = 4'd9;
      3'd1: tap_count = 4'd10;
      3'd2: tap_count = 4'd12;
      3'd3: tap_count = 4'd15;
      3'd4: tap_count = 4'd5;
      3'd5: tap_count = 4'd6;
      3'd6: tap_count = 4'd7;
      default: tap_count = 4'd8;
    endcase
  endfunction

  // clocks from SCL edge to first tap, per scale index
  function automatic logic [6:0] lead_len(input logic [IDX_W-1:0] s);
    case (s)
      3'd0, 3'd1: lead_len = 7'd4;
      3'd2, 3'd3: lead_len = 7'd6;
      3'd4: lead_len = 7'd14;
      3'd5: lead_len = 7'd30;
      3'd6: lead_len = 7'd62;
      default: lead_len = 7'd126;
    endcase
  endfunction
endpackage

// File: rtl/scl_code_decode.sv
module scl_code_decode
  import scl_div_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [CW-1:0]     half_clks,
  output logic [CW-1:0]     lead_clks
);
  logic [IDX_W-1:0] tap_idx;
  logic [IDX_W-1:0] scale_idx;
  logic [3:0]       taps_m1;
  logic [CW-1:0]    spread;

  // tap index split across code bits 5 and 1:0; scale index in 4:2
  assign tap_idx   = {code[5], code[1:0]};
  assign scale_idx = code[4:2];

  always_comb begin
    taps_m1   = tap_count(tap_idx) - 4'd1;
    // spacing is a power of two, so the product is a shift
    spread    = CW'(taps_m1) << scale_idx;
    lead_clks = CW'(lead_len(scale_idx));
    half_clks = lead_clks + spread + CW'(2);
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_div_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] half_in,
  input  logic [CW-1:0] lead_in,
  input  logic          scl_in,
  output logic          idle,
  output logic          scl_low,
  output logic          fall_tick,
  output logic          rise_tick,
  output logic          sample,
  output logic          done
);
  phase_t        phase;
  logic [CW-1:0] low_left;
  logic [CW-1:0] high_seen;
  logic [CW-1:0] half_q;
  logic [CW-1:0] lead_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      low_left  <= '0;
      high_seen <= '0;
      half_q    <= '0;
      lead_q    <= '0;
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
      sample    <= 1'b0;
      done      <= 1'b0;
    end else begin
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
      sample    <= 1'b0;
      done      <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            half_q    <= half_in;
            lead_q    <= lead_in;
            low_left  <= half_in - CW'(1);
            phase     <= PH_LOW;
            fall_tick <= 1'b1;
          end
        end
        PH_LOW: begin
          if (low_left == '0) begin
            phase     <= PH_HIGH;
            high_seen <= '0;
            rise_tick <= 1'b1;
          end else begin
            low_left <= low_left - CW'(1);
          end
        end
        PH_HIGH: begin
          // count only while the line is really high (stretch hold)
          if (scl_in) begin
            if (high_seen == half_q - CW'(1)) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else begin
              high_seen <= high_seen + CW'(1);
            end
            if (high_seen == lead_q - CW'(1)) sample <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle    = (phase == PH_IDLE);
  assign scl_low = (phase == PH_LOW);

  // R4: low-phase counter never exceeds the captured half period
  a_r4_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOW) |-> (low_left < half_q));

  // R8: sensed-low SCL in the high phase freezes the high count
  a_r8_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH && !scl_in) |=> (phase == PH_HIGH && $stable(high_seen)));

  // R9: captured timing is frozen while a bit is in progress
  a_r9_timing_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> (phase == PH_IDLE || ($stable(half_q) && $stable(lead_q))));

  // R7: sample strobe only lands in the high phase
  a_r7_sample_high: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (phase == PH_HIGH));
endmodule

// File: rtl/scl_tap_clkgen.sv
module scl_tap_clkgen
  import scl_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_code,
  input  logic              bit_req_valid,
  output logic              bit_req_ready,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              scl_fall_tick,
  output logic              scl_rise_tick,
  output logic              sda_sample,
  output logic              bit_done
);
  logic [CNT_W-1:0] half_w;
  logic [CNT_W-1:0] lead_w;
  logic             idle_w;
  logic             start_w;

  scl_code_decode #(.CW(CNT_W)) u_dec (
    .code      (div_code),
    .half_clks (half_w),
    .lead_clks (lead_w)
  );

  assign start_w = bit_req_valid && idle_w;

  scl_phase_fsm #(.CW(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .half_in   (half_w),
    .lead_in   (lead_w),
    .scl_in    (scl_in),
    .idle      (idle_w),
    .scl_low   (scl_drive_low),
    .fall_tick (scl_fall_tick),
    .rise_tick (scl_rise_tick),
    .sample    (sda_sample),
    .done      (bit_done)
  );

  assign bit_req_ready = idle_w;

  // R5: ready never coexists with a driven-low SCL
  a_r5_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req_ready |-> !scl_drive_low);

  // R6: tick and strobe pulses never overlap
  a_r6_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_fall_tick, scl_rise_tick, sda_sample, bit_done}));

  // R10: completion coincides with ready returning
  a_r10_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> bit_req_ready);

  // R6: a rise tick follows the last driven-low cycle
  a_r6_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_tick |-> ($past(scl_drive_low) && !scl_drive_low));
endmodule

// File: tb/sim_scl_tap_clkgen.sv
module sim_scl_tap_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] div_code = '0;
  logic       bit_req_valid = 1'b0;
  logic       bit_req_ready;
  logic       scl_in = 1'b1;
  logic       scl_drive_low, scl_fall_tick, scl_rise_tick, sda_sample, bit_done;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  scl_tap_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .div_code(div_code),
    .bit_req_valid(bit_req_valid), .bit_req_ready(bit_req_ready),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .scl_fall_tick(scl_fall_tick), .scl_rise_tick(scl_rise_tick),
    .sda_sample(sda_sample), .bit_done(bit_done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  function automatic int m_taps(input int t);
    int v[8] = '{9, 10, 12, 15, 5, 6, 7, 8};
    return v[t];
  endfunction
  function automatic int m_lead(input int s);
    int v[8] = '{4, 4, 6, 6, 14, 30, 62, 126};
    return v[s];
  endfunction
  function automatic int m_tidx(input int c);
    return ((c >> 3) & 4) | (c & 3);
  endfunction
  function automatic int m_half(input int c);
    int s = (c >> 2) & 7;
    return m_lead(s) + (m_taps(m_tidx(c)) - 1) * (1 << s) + 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one bit with stretch; returns measured cycle indices
  task automatic run_bit(input int code, input int stretch);
    int k = 0, low_n = 0, rise_k = -1, rise_n = 0, fall_k = -1, fall_n = 0;
    int samp_k = -1, samp_n = 0, done_k = -1, rdy_bad = 0, left = 0;
    int h = m_half(code);
    int ld = m_lead((code >> 2) & 7);
    @(negedge clk);
    chk(bit_req_ready == 1'b1, "R5 ready before request", bit_req_ready, 1);
    div_code = 6'(code);
    bit_req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bit_req_valid = 1'b0;
    div_code = ~6'(code);   // R9: change code mid-bit
    while (k < 5000) begin
      if (scl_drive_low) low_n++;
      if (scl_fall_tick) begin fall_n++; fall_k = k; end
      if (scl_rise_tick) begin rise_n++; rise_k = k; left = stretch; end
      if (sda_sample) begin samp_n++; samp_k = k; end
      if (!bit_done && bit_req_ready) rdy_bad++;
      if (left > 0) begin scl_in = 1'b0; left--; end
      else scl_in = !scl_drive_low;
      if (bit_done) begin done_k = k; break; end
      @(negedge clk);
      k++;
    end
    scl_in = 1'b1;
    chk(low_n == h, "R4/R2/R3/R9 low cycles", low_n, h);
    chk(fall_n == 1 && fall_k == 0, "R6 fall tick cycle", fall_k, 0);
    chk(rise_n == 1 && rise_k == h, "R6 rise tick cycle", rise_k, h);
    chk(samp_n == 1 && samp_k == h + stretch + ld, "R7/R8 sample cycle", samp_k, h + stretch + ld);
    chk(done_k == 2 * h + stretch, "R10/R4/R8 done cycle", done_k, 2 * h + stretch);
    chk(rdy_bad == 0, "R5 ready low while busy", rdy_bad, 0);
  endtask

  initial begin
    #1;
    chk(bit_req_ready == 1'b1, "R1 ready at reset", bit_req_ready, 1);
    chk({scl_drive_low, scl_fall_tick, scl_rise_tick, sda_sample, bit_done} == 5'b0,
        "R1 outputs quiet at reset",
        int'({scl_drive_low, scl_fall_tick, scl_rise_tick, sda_sample, bit_done}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_req_ready == 1'b1 && !scl_drive_low, "R1 idle after reset", bit_req_ready, 1);

    // sweep every code without stretching
    for (int c = 0; c < 64; c++) run_bit(c, 0);

    // stretching on a few codes
    run_bit(6'h20, 3);
    run_bit(6'h00, 7);
    run_bit(6'h0D, 1);

    // R5: valid held through a bit; next bit starts right after done
    begin
      int k = 0, fall_ks = 0, fall_k2 = -1, rdy_bad = 0, done_seen = 0;
      int h = m_half(6'h20);
      @(negedge clk);
      div_code = 6'h20;
      bit_req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      while (k < 200) begin
        if (scl_fall_tick) begin fall_ks++; if (k > 0) fall_k2 = k; end
        if (bit_req_ready && !bit_done) rdy_bad++;
        if (bit_done) done_seen = 1;
        scl_in = !scl_drive_low;
        if (fall_k2 >= 0) break;
        @(negedge clk);
        k++;
      end
      bit_req_valid = 1'b0;
      chk(done_seen == 1 && rdy_bad == 0, "R5 held valid not taken early", rdy_bad, 0);
      chk(fall_k2 == 2 * h + 1, "R5 back-to-back start", fall_k2, 2 * h + 1);
      while (!bit_done) begin
        @(negedge clk);
        scl_in = !scl_drive_low;
      end
      scl_in = 1'b1;
      @(negedge clk);
      chk(bit_req_ready == 1'b1, "R10 idle after second bit", bit_req_ready, 1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule